// File: doc/BRIEF.md
# Serial Converter Command and Data-Out Interface

This block is the digital side of a serial sampling converter. A host frames each exchange by holding the chip select low. On every serial bit strobe the block takes one instruction bit from the input pin and moves one bit of the held output word onto the output pin. The first eight bits of a frame form the instruction. The block decodes that instruction when the chip select is released.

Some instructions only change configuration: the acquisition window, the sign bit, and the user or test mode. Others start work. A conversion instruction picks a channel, a resolution and a bit order, then runs a timed conversion while the end-of-conversion pin is held low. Calibration and the power sequences run a timed sequence that is visible only in the status word. A read-status instruction places the 9-bit status word in the output register for the next frame.

The analog conversion is replaced by a counter of completed conversions. Every result is therefore predictable. The word shifted out during a frame is always the one held from before that frame. Its length and bit order are those chosen by the conversion instruction that produced it.

Top module: `sadc_ser_if`

## Requirements
- R1: After reset the status word reads 0x0D1: 12-bit format, sign included, MSB first, user mode, and power-up in progress (bit 0). Bit 0 clears after PWR_CYC clocks. While CS is high, `eoc` is 1 and `sdo` is 0.
- R2: An instruction is the first 8 bits of a frame, MSB first, with the opcode in bits 7:5. Bits after the eighth are ignored. A frame with fewer than 8 bits changes nothing.
- R3: A conversion instruction has opcode 000, channel in bits 4:3, LSB-first flag in bit 2, and format in bits 1:0 (0 = 8-bit, 1 = 12-bit, 2 or 3 = 16-bit). It drives `eoc` low for exactly the acquisition clocks plus CONV_CYC clocks. It also sets the configured format and bit order.
- R4: An acquisition instruction (opcode 001, code in bits 1:0) selects an acquisition time of 6, 10, 18 or 34 clocks for codes 0 to 3. It starts no conversion.
- R5: A sign instruction (opcode 010, bit 0) turns the sign bit on or off for later conversions. It starts no conversion.
- R6: Conversion k (counting from 0 after reset) has the 16-bit magnitude {channel, k[13:0]} and the sign bit k[0]. The MSB-first word is the sign bit (if enabled), then the top N magnitude bits, MSB first. With the LSB-first flag set, the same bits are sent in reverse order.
- R7: Data shifted out during any frame is the latest completed result. Configuration-only frames and conversion-start frames both return it unchanged.
- R8: A read-status instruction (opcode 011) makes the next frame return the status word, bit 8 first. The bits are: 0 power-up busy, 1 power-down busy, 2 calibration busy, 3/4/5 one-hot for 8/12/16-bit format, 6 sign on, 7 MSB first, 8 test mode.
- R9: A CS falling edge during a conversion ends it: `eoc` is high one clock later, no result is stored, and the conversion count does not advance.
- R10: A calibration instruction (opcode 100) sets status bit 2 for CAL_CYC clocks. The next frame shifts out all ones. `eoc` stays high.
- R11: A mode instruction (opcode 101, bit 0) sets status bit 8. A power instruction (opcode 110) starts a power-down sequence when bit 0 is 1, or a power-up sequence when bit 0 is 0. The sequence shows in status bit 1 or bit 0 for PWR_CYC clocks.
- R12: Bit times after the end of the output word read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| bit_en | input | 1 | Serial bit strobe, one clock wide |
| sdi | input | 1 | Serial instruction input |
| sdo | output | 1 | Serial data output, 0 while CS is high |
| eoc | output | 1 | Low while a conversion is running |

## Verification
The block has several internal states that can go wrong.

- **Configuration register.** A corrupted configuration bit shows up twice: in the status word read two frames later, and in the length or bit order of the next result read after its conversion.
- **Sequence timer.** A wrong timer load or count shows in the low time of `eoc`, measured to the exact clock, or in how long a busy bit stays set in status.
- **Held result.** A held result that is overwritten by mistake shows in the very next frame, because every frame replays it. This includes a configuration-only frame and a frame that aborts a conversion.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_MAX = 16;
  localparam int WORD_W  = RES_MAX + 1;
  localparam int STAT_W  = 9;
  localparam int INS_W   = 8;
  localparam int CNT_W   = RES_MAX - 2;

  typedef enum logic [2:0] {
    OP_CONV = 3'd0, OP_ACQ = 3'd1, OP_SIGN = 3'd2, OP_STAT = 3'd3,
    OP_CAL  = 3'd4, OP_MODE = 3'd5, OP_PWR = 3'd6, OP_NOP = 3'd7
  } op_e;

  typedef enum logic [1:0] {SEQ_PU, SEQ_PD, SEQ_CAL, SEQ_CONV} seq_e;

  // Left-aligned output word in transmit order, zero filled after its end.
  function automatic logic [WORD_W-1:0] build_word(input logic [1:0] fmt, input logic sgn,
                                                   input logic lsbf, input logic [RES_MAX-1:0] mag,
                                                   input logic sbit);
    logic [WORD_W-1:0] w;
    logic [WORD_W-1:0] r;
    int n;
    int len;
    int off;
    n   = (fmt == 2'd0) ? 8 : (fmt == 2'd1) ? 12 : 16;
    off = sgn ? 1 : 0;
    len = n + off;
    w   = '0;
    r   = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (sgn && i == 0) w[WORD_W-1] = sbit;
      else if (i < len) w[WORD_W-1-i] = mag[RES_MAX-1-(i-off)];
    end
    for (int i = 0; i < WORD_W; i++) begin
      if (i < len) r[WORD_W-1-i] = w[WORD_W-len+i];
    end
    return lsbf ? r : w;
  endfunction
endpackage

// File: rtl/sadc_frame_rx.sv
module sadc_frame_rx
  import sadc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             bit_en,
  input  logic             sdi,
  output logic             fr_start,
  output logic             fr_end,
  output logic             ins_ok,
  output logic [INS_W-1:0] ins
);
  localparam int BC_W = $clog2(INS_W + 1);

  logic             cs_q;
  logic [BC_W-1:0]  bc_q, bc_n, bc_base;
  logic [INS_W-1:0] ins_q, ins_n;

  assign fr_start = cs_q & ~cs_n;
  assign fr_end   = ~cs_q & cs_n;
  assign ins_ok   = (bc_q == BC_W'(INS_W));
  assign ins      = ins_q;

  always_comb begin
    bc_base = fr_start ? '0 : bc_q;
    bc_n    = bc_base;
    ins_n   = ins_q;
    if (bit_en && !cs_n && bc_base < BC_W'(INS_W)) begin
      ins_n = {ins_q[INS_W-2:0], sdi};
      bc_n  = bc_base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      bc_q  <= '0;
      ins_q <= '0;
    end else begin
      cs_q  <= cs_n;
      bc_q  <= bc_n;
      ins_q <= ins_n;
    end
  end
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int CONV_CYC = 8,
  parameter int CAL_CYC  = 64,
  parameter int PWR_CYC  = 64,
  parameter int TMR_W    = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_start,
  input  logic              fr_end,
  input  logic              ins_ok,
  input  logic [INS_W-1:0]  ins,
  output logic [STAT_W-1:0] stat,
  output logic              eoc,
  output logic              done,
  output logic [WORD_W-1:0] done_word,
  output logic              ld_stat,
  output logic              ld_cal
);
  op_e              op;
  logic [1:0]       fmt_q, fmt_n, acq_q, acq_n, cv_fmt_q, cv_fmt_n, cv_ch_q, cv_ch_n;
  logic             sign_q, sign_n, lsb_q, lsb_n, test_q, test_n;
  logic             cv_sgn_q, cv_sgn_n, cv_lsb_q, cv_lsb_n;
  logic             busy_q, busy_n;
  seq_e             kind_q, kind_n;
  logic [TMR_W-1:0] tmr_q, tmr_n, acq_len;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign op      = op_e'(ins[INS_W-1 -: 3]);
  assign acq_len = (TMR_W'(4) << acq_q) + TMR_W'(2) + TMR_W'(CONV_CYC);
  assign eoc     = ~(busy_q && kind_q == SEQ_CONV);
  assign stat    = {test_q, ~lsb_q, sign_q, fmt_q == 2'd2, fmt_q == 2'd1, fmt_q == 2'd0,
                    busy_q && kind_q == SEQ_CAL, busy_q && kind_q == SEQ_PD,
                    busy_q && kind_q == SEQ_PU};
  assign done_word = build_word(cv_fmt_q, cv_sgn_q, cv_lsb_q, {cv_ch_q, cnt_q}, cnt_q[0]);

  always_comb begin
    fmt_n = fmt_q;  acq_n = acq_q;  sign_n = sign_q;  lsb_n = lsb_q;  test_n = test_q;
    cv_fmt_n = cv_fmt_q;  cv_ch_n = cv_ch_q;  cv_sgn_n = cv_sgn_q;  cv_lsb_n = cv_lsb_q;
    busy_n = busy_q;  kind_n = kind_q;  tmr_n = tmr_q;  cnt_n = cnt_q;
    done = 1'b0;  ld_stat = 1'b0;  ld_cal = 1'b0;
    if (busy_q) begin
      if (tmr_q <= TMR_W'(1)) begin
        busy_n = 1'b0;
        if (kind_q == SEQ_CONV) begin
          done  = 1'b1;
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        tmr_n = tmr_q - 1'b1;
      end
    end
    if (fr_start && busy_q && kind_q == SEQ_CONV) begin
      busy_n = 1'b0;
      done   = 1'b0;
      cnt_n  = cnt_q;
    end
    if (fr_end && ins_ok) begin
      case (op)
        OP_CONV: begin
          fmt_n    = (ins[1:0] == 2'd3) ? 2'd2 : ins[1:0];
          lsb_n    = ins[2];
          cv_fmt_n = fmt_n;
          cv_lsb_n = ins[2];
          cv_ch_n  = ins[4:3];
          cv_sgn_n = sign_q;
          busy_n   = 1'b1;
          kind_n   = SEQ_CONV;
          tmr_n    = acq_len;
        end
        OP_ACQ:  acq_n  = ins[1:0];
        OP_SIGN: sign_n = ins[0];
        OP_STAT: ld_stat = 1'b1;
        OP_CAL: begin
          ld_cal = 1'b1;
          busy_n = 1'b1;
          kind_n = SEQ_CAL;
          tmr_n  = TMR_W'(CAL_CYC);
        end
        OP_MODE: test_n = ins[0];
        OP_PWR: begin
          busy_n = 1'b1;
          kind_n = ins[0] ? SEQ_PD : SEQ_PU;
          tmr_n  = TMR_W'(PWR_CYC);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= 2'd1;  acq_q <= 2'd1;  sign_q <= 1'b1;  lsb_q <= 1'b0;  test_q <= 1'b0;
      cv_fmt_q <= 2'd1;  cv_ch_q <= '0;  cv_sgn_q <= 1'b1;  cv_lsb_q <= 1'b0;
      busy_q <= 1'b1;  kind_q <= SEQ_PU;  tmr_q <= TMR_W'(PWR_CYC);  cnt_q <= '0;
    end else begin
      fmt_q <= fmt_n;  acq_q <= acq_n;  sign_q <= sign_n;  lsb_q <= lsb_n;  test_q <= test_n;
      cv_fmt_q <= cv_fmt_n;  cv_ch_q <= cv_ch_n;  cv_sgn_q <= cv_sgn_n;  cv_lsb_q <= cv_lsb_n;
      busy_q <= busy_n;  kind_q <= kind_n;  tmr_q <= tmr_n;  cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/sadc_out_sr.sv
module sadc_out_sr
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_en,
  input  logic              fr_end,
  input  logic              ld_stat,
  input  logic              ld_cal,
  input  logic [STAT_W-1:0] stat,
  input  logic              done,
  input  logic [WORD_W-1:0] done_word,
  output logic              sdo
);
  logic [WORD_W-1:0] res_q, res_n, sh_q, sh_n;

  assign sdo = ~cs_n & sh_q[WORD_W-1];

  always_comb begin
    res_n = res_q;
    sh_n  = sh_q;
    if (done) begin
      res_n = done_word;
      sh_n  = done_word;
    end else if (fr_end) begin
      if (ld_stat)     sh_n = {stat, {(WORD_W-STAT_W){1'b0}}};
      else if (ld_cal) sh_n = '1;
      else             sh_n = res_q;
    end else if (bit_en && !cs_n) begin
      sh_n = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      sh_q  <= '0;
    end else begin
      res_q <= res_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/sadc_ser_if.sv
module sadc_ser_if
  import sadc_pkg::*;
#(
  parameter int CONV_CYC = 8,
  parameter int CAL_CYC  = 64,
  parameter int PWR_CYC  = 64,
  parameter int TMR_W    = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic bit_en,
  input  logic sdi,
  output logic sdo,
  output logic eoc
);
  logic              fr_start, fr_end, ins_ok, done, ld_stat, ld_cal;
  logic [INS_W-1:0]  ins_w;
  logic [STAT_W-1:0] stat_w;
  logic [WORD_W-1:0] done_word;

  sadc_frame_rx rx_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi),
    .fr_start(fr_start), .fr_end(fr_end), .ins_ok(ins_ok), .ins(ins_w)
  );

  sadc_ctrl #(.CONV_CYC(CONV_CYC), .CAL_CYC(CAL_CYC), .PWR_CYC(PWR_CYC), .TMR_W(TMR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fr_start(fr_start), .fr_end(fr_end), .ins_ok(ins_ok),
    .ins(ins_w), .stat(stat_w), .eoc(eoc), .done(done), .done_word(done_word),
    .ld_stat(ld_stat), .ld_cal(ld_cal)
  );

  sadc_out_sr sr_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .fr_end(fr_end),
    .ld_stat(ld_stat), .ld_cal(ld_cal), .stat(stat_w), .done(done),
    .done_word(done_word), .sdo(sdo)
  );
endmodule

// File: rtl/sadc_ser_if_chk.sv
module sadc_ser_if_chk #(
  parameter int CONV_CYC = 8
)(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       eoc,
  input logic       fr_end,
  input logic       ins_ok,
  input logic [7:0] ins_w,
  input logic [8:0] stat_w
);
  localparam int MAXB = 34 + CONV_CYC;
  localparam int LW   = $clog2(MAXB + 2);

  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_q <= '0;
    else if (eoc)                   low_q <= '0;
    else if (low_q <= LW'(MAXB))    low_q <= low_q + 1'b1;
  end

  a_r9_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !eoc) |=> eoc);
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_end && ins_ok && ins_w[7:5] == 3'd0) |=> !eoc);
  a_r4_cfg_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_end && ins_ok && (ins_w[7:5] == 3'd1 || ins_w[7:5] == 3'd2) && eoc) |=> eoc);
  a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= LW'(MAXB));
  a_r8_fmt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(stat_w[5:3]));
  a_r11_seq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_w[2:0]));
endmodule

bind sadc_ser_if sadc_ser_if_chk #(.CONV_CYC(CONV_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .eoc(eoc), .fr_end(fr_end),
  .ins_ok(ins_ok), .ins_w(ins_w), .stat_w(stat_w)
);

// File: tb/sadc_ser_if_tb_top.sv
module sadc_ser_if_tb_top;
  localparam int CONV_CYC = 8;
  localparam int CAL_CYC  = 64;
  localparam int PWR_CYC  = 64;

  logic clk, rst_n, cs_n, bit_en, sdi, sdo, eoc;
  int n_chk = 0, n_bad = 0;
  int cnt = 0;
  logic [16:0] got, prev_exp;
  int cfg_fmt = 1, cfg_sign = 1, cfg_lsb = 0, cfg_test = 0;

  sadc_ser_if #(.CONV_CYC(CONV_CYC), .CAL_CYC(CAL_CYC), .PWR_CYC(PWR_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_en(bit_en), .sdi(sdi), .sdo(sdo), .eoc(eoc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] ins, input int nbits, output logic [16:0] q);
    q = '0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i < 17) q[16-i] = sdo;
      sdi = (i < 8) ? ins[7-i] : 1'b1;
      bit_en = 1'b1;
    end
    @(negedge clk) bit_en = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!eoc && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [16:0] stat_word(input logic pu, input logic pd, input logic cal);
    logic [8:0] s;
    s = {cfg_test[0], ~cfg_lsb[0], cfg_sign[0], cfg_fmt == 2, cfg_fmt == 1, cfg_fmt == 0, cal, pd, pu};
    return {s, 8'h00};
  endfunction

  function automatic logic [16:0] model(input int fmt, input int sg, input int lsb,
                                        input int ch, input int k);
    logic [15:0] mag;
    logic [16:0] e;
    logic        b;
    int n, len;
    mag = {ch[1:0], k[13:0]};
    n   = 8 + 4 * fmt;
    len = n + sg;
    e   = '0;
    for (int t = 0; t < len; t++) begin
      int j;
      j = lsb ? (len - 1 - t) : t;
      if (sg == 1 && j == 0) b = k[0];
      else b = mag[15 - (j - sg)];
      e[16 - t] = b;
    end
    return e;
  endfunction

  task automatic read_status(input logic pu, input logic pd, input logic cal, input string tag);
    logic [16:0] q;
    frame(8'h60, 17, q);
    frame(8'hE0, 17, q);
    chk(q, stat_word(pu, pd, cal), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bl;
    rst_n = 1'b0; cs_n = 1'b1; bit_en = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eoc, 1, "R1 eoc after reset");
    chk(sdo, 0, "R1 sdo idle");
    read_status(1'b1, 1'b0, 1'b0, "R1 R8 reset status with power-up busy");
    repeat (PWR_CYC + 10) @(negedge clk);
    read_status(1'b0, 1'b0, 1'b0, "R1 power-up finished");

    // R2: short frame with a sign-off opcode is ignored
    frame(8'h40, 4, got);
    read_status(1'b0, 1'b0, 1'b0, "R2 short frame ignored");

    // R3 R5 R6 R7: sweep format, order, sign
    for (int f = 0; f < 3; f++)
      for (int l = 0; l < 2; l++)
        for (int s = 0; s < 2; s++) begin
          int ch;
          ch = (f * 4 + l * 2 + s) & 3;
          frame(8'h40 | 8'(s), 17, got);
          if (cnt > 0) chk(got, prev_exp, "R7 sign frame replays result");
          chk(eoc, 1, "R5 sign frame starts nothing");
          cfg_sign = s;
          frame({3'b000, 2'(ch), 1'(l), 2'(f)}, 17, got);
          if (cnt > 0) chk(got, prev_exp, "R6 R12 previous result");
          busy_len(bl);
          chk(bl, 10 + CONV_CYC, "R3 busy length default acq");
          cfg_fmt = f; cfg_lsb = l;
          prev_exp = model(f, s, l, ch, cnt);
          cnt++;
        end
    frame(8'hE0, 17, got);
    chk(got, prev_exp, "R6 last sweep result");
    read_status(1'b0, 1'b0, 1'b0, "R8 status after sweep");

    // R4: acquisition codes
    for (int a = 0; a < 4; a++) begin
      frame(8'h20 | 8'(a), 17, got);
      chk(got, prev_exp, "R7 acq frame replays result");
      chk(eoc, 1, "R4 acq frame starts nothing");
      frame(8'h0D, 17, got);
      busy_len(bl);
      chk(bl, (4 << a) + 2 + CONV_CYC, "R4 acquisition time");
      cfg_fmt = 1; cfg_lsb = 1;
      prev_exp = model(1, cfg_sign, 1, 1, cnt);
      cnt++;
    end
    frame(8'hE0, 17, got);
    chk(got, prev_exp, "R6 LSB-first after acq sweep");

    // R9: abort a running conversion
    frame(8'h02, 17, got);
    chk(eoc, 0, "R9 conversion running");
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk(eoc, 1, "R9 abort raises eoc");
    cs_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(eoc, 1, "R9 no restart");
    cfg_fmt = 2; cfg_lsb = 0;
    frame(8'hE0, 17, got);
    chk(got, prev_exp, "R9 result unchanged after abort");
    frame(8'h00, 17, got);
    busy_len(bl);
    frame(8'hE0, 17, got);
    cfg_fmt = 0;
    chk(got, model(0, cfg_sign, 0, 0, cnt), "R9 count not advanced");
    prev_exp = model(0, cfg_sign, 0, 0, cnt);
    cnt++;

    // R10: calibration
    frame(8'h80, 17, got);
    chk(eoc, 1, "R10 eoc high during calibration");
    frame(8'h60, 17, got);
    chk(got, 17'h1FFFF, "R10 output overwritten");
    frame(8'hE0, 17, got);
    chk(got, stat_word(1'b0, 1'b0, 1'b1), "R10 cal busy bit");
    repeat (CAL_CYC + 10) @(negedge clk);
    read_status(1'b0, 1'b0, 1'b0, "R10 cal finished");

    // R11: test mode and power sequences
    frame(8'hA1, 17, got);
    cfg_test = 1;
    frame(8'hC1, 17, got);
    read_status(1'b0, 1'b1, 1'b0, "R11 test mode and power-down busy");
    repeat (PWR_CYC + 10) @(negedge clk);
    frame(8'hC0, 17, got);
    read_status(1'b1, 1'b0, 1'b0, "R11 power-up busy");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule